// File: doc/BRIEF.md
# Half-Rate Complex Decision Feedback Equalizer for QPSK

This block turns quantized QPSK baseband samples into hard symbol decisions while removing inter-symbol interference left by the channel. Each clock cycle carries two consecutive symbols. The earlier symbol is in the even lane and the later one is in the odd lane, so each lane runs at half the symbol rate. Every symbol has an in-phase (I) and a quadrature (Q) sample. The block returns one I bit and one Q bit for each lane.

Interference from the four symbols before the previous one is subtracted before slicing. Each channel's summing point takes eight feedback terms: four weighted by the same channel's past decisions and four weighted by the other channel's past decisions. The previous symbol is not fed back. Instead, each lane and channel has four comparators, one for each possible previous QPSK symbol, and each comparator has its own programmable offset. That offset holds both the comparator's offset correction and the first-tap weight. Once the previous symbol is known, it picks one comparator result. For the even lane the previous symbol is the odd decision of the cycle before. For the odd lane it is the even decision made in the same cycle. Coefficients and offsets are static configuration inputs.

Top module: `dfe_halfrate_cplx`

## Requirements
- R1: The reset is synchronous and active low. While `rst_n` is sampled low, the decision history is set to five symbols of +1, so all four decision outputs read 1 after that edge. After release, the first symbols are equalized as if all earlier decisions were +1. This also holds when reset is applied in the middle of a stream.
- R2: The decisions for the sample pair present before a rising clock edge appear on the decision outputs right after that edge, and they hold for one cycle.
- R3: Each decision bit is 1 when `sample - isi + offset >= 0` and 0 otherwise. A result of exactly zero gives 1. Samples are 8-bit two's complement.
- R4: Comparator offsets are 8-bit two's complement. The offset for lane L (0 = even, 1 = odd), channel c (0 = I, 1 = Q) and hypothesis h sits at `comp_ofs[((L*2+c)*4+h)*8 +: 8]`. The hypothesis index is h = 2*prevI + prevQ. The even lane uses the odd decision of the previous pair as its previous symbol.
- R5: The odd lane uses the same pair's even decision (both I and Q) as its previous symbol.
- R6: Direct tap weights are 6-bit two's complement. The weight for channel c and tap t (2..5) is at `tap_coef[(c*8+(t-2))*6 +: 6]`. Each term adds the weight to `isi` when channel c's decision for symbol n-t was 1, and subtracts it when that decision was 0.
- R7: Cross tap weights for channel c are at `tap_coef[(c*8+4+(t-2))*6 +: 6]`. Each term is signed by the other channel's decision for symbol n-t, using the same sign rule as R6.
- R8: Tap t always uses symbol n-t of the full-rate stream, including across pair boundaries. Tap 5 of an even symbol reaches three cycles back, to the odd symbol of that cycle.
- R9: The sum is computed at full precision. Extreme samples (-128/127), extreme weights (-32/31) and extreme offsets (-128/127) never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per symbol pair |
| rst_n | input | 1 | Synchronous active-low reset |
| x_ev_i | input | 8 | Even-lane I sample |
| x_ev_q | input | 8 | Even-lane Q sample |
| x_od_i | input | 8 | Odd-lane I sample |
| x_od_q | input | 8 | Odd-lane Q sample |
| comp_ofs | input | 128 | Sixteen comparator offsets, laid out as in R4 |
| tap_coef | input | 96 | Direct and cross weights for taps 2 to 5, laid out as in R6 and R7 |
| dec_ev_i | output | 1 | Even-lane I decision |
| dec_ev_q | output | 1 | Even-lane Q decision |
| dec_od_i | output | 1 | Odd-lane I decision |
| dec_od_q | output | 1 | Odd-lane Q decision |

## Verification
The hardest case to reach is one where the four hypotheses of a comparator group disagree. The result then depends on the selection chain: the odd lane's choice depends on the even decision made in the same cycle, and that decision depends on the previous cycle. To create it, the stimulus spreads the offsets widely and gives them different signs for each hypothesis, then drives pseudo-random samples of moderate amplitude so that the chosen candidate changes from pair to pair. A full-rate reference model runs alongside to provide the expected bits. Tap reach across pair boundaries is isolated by a configuration where only tap 5 carries a large weight and the samples are small.

// File: rtl/dfe_pkg.sv
// Shared types and helpers for the half-rate complex equalizer.
// Assumes QPSK: one I bit and one Q bit per symbol, where bit 1 stands for +1.
package dfe_pkg;

    // One decided QPSK symbol
    typedef struct packed {
        logic i;
        logic q;
    } sym_t;

    localparam sym_t SYM_POS = '{i: 1'b1, q: 1'b1};
    localparam int   CH_I    = 0;
    localparam int   CH_Q    = 1;

    // Pick the bit of one channel out of a symbol
    function automatic logic chan_bit(sym_t s, int ch);
        return (ch == CH_I) ? s.i : s.q;
    endfunction

    // Hypothesis index of a previous symbol: 2*I + Q
    function automatic logic [1:0] hyp_of(sym_t s);
        return {s.i, s.q};
    endfunction

endpackage

// File: rtl/dfe_isi_sum.sv
// Sums the post-cursor feedback terms for one lane and one channel.
// Each term adds or subtracts a signed weight according to a past decision bit
// (1 = +1, 0 = -1). Assumes ACC_W is wide enough that the sum cannot wrap.
module dfe_isi_sum #(
    parameter int NFB    = 4,
    parameter int COEF_W = 6,
    parameter int ACC_W  = 11
) (
    input  logic [NFB*COEF_W-1:0]    coef_own,
    input  logic [NFB*COEF_W-1:0]    coef_crs,
    input  logic [NFB-1:0]           past_own,
    input  logic [NFB-1:0]           past_crs,
    output logic signed [ACC_W-1:0]  isi_o
);

    logic signed [ACC_W-1:0] w_own [NFB];
    logic signed [ACC_W-1:0] w_crs [NFB];

    // Sign-extend every weight to the accumulator width
    for (genvar k = 0; k < NFB; k++) begin : g_ext
        assign w_own[k] = ACC_W'(signed'(coef_own[k*COEF_W +: COEF_W]));
        assign w_crs[k] = ACC_W'(signed'(coef_crs[k*COEF_W +: COEF_W]));
    end

    // Accumulate direct and cross terms with their decision signs
    always_comb begin
        isi_o = '0;
        for (int k = 0; k < NFB; k++) begin
            isi_o = past_own[k] ? isi_o + w_own[k] : isi_o - w_own[k];
            isi_o = past_crs[k] ? isi_o + w_crs[k] : isi_o - w_crs[k];
        end
    end

endmodule

// File: rtl/dfe_spec_slicer.sv
// Speculative slicer group: one comparator per previous-symbol hypothesis.
// Each comparator adds its own offset, which also carries the first-tap weight,
// to the equalized sample and outputs 1 when the result is non-negative.
module dfe_spec_slicer #(
    parameter int SAMPLE_W = 8,
    parameter int OFS_W    = 8,
    parameter int ACC_W    = 11,
    parameter int NHYP     = 4
) (
    input  logic [SAMPLE_W-1:0]     sample_i,
    input  logic signed [ACC_W-1:0] isi_i,
    input  logic [NHYP*OFS_W-1:0]   ofs_i,
    output logic [NHYP-1:0]         cand_o
);

    logic signed [ACC_W-1:0] eq_val;

    // Remove post-cursor interference from the raw sample
    assign eq_val = ACC_W'(signed'(sample_i)) - isi_i;

    for (genvar h = 0; h < NHYP; h++) begin : g_cmp
        logic signed [ACC_W-1:0] lvl;
        // Apply this hypothesis' threshold and slice on the sign
        assign lvl       = eq_val + ACC_W'(signed'(ofs_i[h*OFS_W +: OFS_W]));
        assign cand_o[h] = ~lvl[ACC_W-1];
    end

endmodule

// File: rtl/dfe_tap1_select.sv
// Resolves the loop-unrolled first tap for a symbol pair.
// The even lane picks its candidates with the last symbol of the previous pair.
// The odd lane then picks its own with the even decision just made.
module dfe_tap1_select
    import dfe_pkg::*;
(
    input  logic [3:0] cand_ev_i,
    input  logic [3:0] cand_ev_q,
    input  logic [3:0] cand_od_i,
    input  logic [3:0] cand_od_q,
    input  sym_t       prev_i,
    output sym_t       dec_ev_o,
    output sym_t       dec_od_o
);

    // Two chained selections: even first, odd on the even result
    always_comb begin
        dec_ev_o.i = cand_ev_i[hyp_of(prev_i)];
        dec_ev_o.q = cand_ev_q[hyp_of(prev_i)];
        dec_od_o.i = cand_od_i[hyp_of(dec_ev_o)];
        dec_od_o.q = cand_od_q[hyp_of(dec_ev_o)];
    end

endmodule

// File: rtl/dfe_history.sv
// Full-rate decision history, stored newest first: entry 0 is the last odd
// decision and entry 1 the last even decision. Two entries shift in each cycle.
// Reset fills it with +1 symbols. Assumes DEPTH >= 2.
module dfe_history
    import dfe_pkg::*;
#(
    parameter int DEPTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sym_t             new_ev_i,
    input  sym_t             new_od_i,
    output sym_t [DEPTH-1:0] hist_o
);

    // Shift the newest pair in and age the rest by two symbols
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) hist_o[j] <= SYM_POS;
        end else begin
            hist_o[0] <= new_od_i;
            hist_o[1] <= new_ev_i;
            for (int j = 2; j < DEPTH; j++) hist_o[j] <= hist_o[j-2];
        end
    end

endmodule

// File: rtl/dfe_halfrate_cplx.sv
// Half-rate complex decision feedback equalizer for QPSK.
// Two symbols arrive per cycle (even, then odd). Taps 2..NTAP are subtracted
// as direct and cross-channel terms. Tap 1 is speculated over the four
// possible previous symbols and resolved in tap1_select. Decisions are
// registered in the history and appear one cycle after their samples.
// Assumes NTAP >= 3 and static configuration inputs.
module dfe_halfrate_cplx
    import dfe_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int COEF_W   = 6,
    parameter int OFS_W    = 8,
    parameter int NTAP     = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SAMPLE_W-1:0]           x_ev_i,
    input  logic [SAMPLE_W-1:0]           x_ev_q,
    input  logic [SAMPLE_W-1:0]           x_od_i,
    input  logic [SAMPLE_W-1:0]           x_od_q,
    input  logic [16*OFS_W-1:0]           comp_ofs,
    input  logic [4*(NTAP-1)*COEF_W-1:0]  tap_coef,
    output logic                          dec_ev_i,
    output logic                          dec_ev_q,
    output logic                          dec_od_i,
    output logic                          dec_od_q
);

    localparam int NFB   = NTAP - 1;
    localparam int NLANE = 2;
    localparam int NCH   = 2;
    localparam int NHYP  = 4;
    localparam int NCOMP = NLANE * NCH * NHYP;
    localparam int W_IO  = (SAMPLE_W > OFS_W) ? SAMPLE_W : OFS_W;
    localparam int W_ISI = COEF_W + $clog2(2 * NFB);
    localparam int ACC_W = ((W_IO > W_ISI) ? W_IO : W_ISI) + 2;

    logic [SAMPLE_W-1:0] x_in [NLANE][NCH];
    logic [NHYP-1:0]     cand [NLANE][NCH];
    logic [NCOMP-1:0]    cand_flat;
    sym_t [NTAP-1:0]     hist_q;
    sym_t                dec_ev;
    sym_t                dec_od;

    // Arrange the sample ports as [lane][channel]
    assign x_in[0][CH_I] = x_ev_i;
    assign x_in[0][CH_Q] = x_ev_q;
    assign x_in[1][CH_I] = x_od_i;
    assign x_in[1][CH_Q] = x_od_q;

    for (genvar L = 0; L < NLANE; L++) begin : g_lane
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            localparam int OC = NCH - 1 - c;
            logic [NFB-1:0]          past_own;
            logic [NFB-1:0]          past_crs;
            logic signed [ACC_W-1:0] isi;

            // Tap k+2 of lane L looks at history entry k+1-L
            for (genvar k = 0; k < NFB; k++) begin : g_fb
                assign past_own[k] = chan_bit(hist_q[k+1-L], c);
                assign past_crs[k] = chan_bit(hist_q[k+1-L], OC);
            end

            dfe_isi_sum #(
                .NFB    (NFB),
                .COEF_W (COEF_W),
                .ACC_W  (ACC_W)
            ) u_isi (
                .coef_own (tap_coef[(c*2*NFB)*COEF_W +: NFB*COEF_W]),
                .coef_crs (tap_coef[(c*2*NFB+NFB)*COEF_W +: NFB*COEF_W]),
                .past_own (past_own),
                .past_crs (past_crs),
                .isi_o    (isi)
            );

            dfe_spec_slicer #(
                .SAMPLE_W (SAMPLE_W),
                .OFS_W    (OFS_W),
                .ACC_W    (ACC_W),
                .NHYP     (NHYP)
            ) u_slc (
                .sample_i (x_in[L][c]),
                .isi_i    (isi),
                .ofs_i    (comp_ofs[((L*NCH+c)*NHYP)*OFS_W +: NHYP*OFS_W]),
                .cand_o   (cand[L][c])
            );

            // Flatten the candidates for the bound checker
            assign cand_flat[(L*NCH+c)*NHYP +: NHYP] = cand[L][c];
        end
    end

    dfe_tap1_select u_sel (
        .cand_ev_i (cand[0][CH_I]),
        .cand_ev_q (cand[0][CH_Q]),
        .cand_od_i (cand[1][CH_I]),
        .cand_od_q (cand[1][CH_Q]),
        .prev_i    (hist_q[0]),
        .dec_ev_o  (dec_ev),
        .dec_od_o  (dec_od)
    );

    dfe_history #(
        .DEPTH (NTAP)
    ) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .new_ev_i (dec_ev),
        .new_od_i (dec_od),
        .hist_o   (hist_q)
    );

    // The two newest history entries are the registered decisions
    assign dec_ev_i = hist_q[1].i;
    assign dec_ev_q = hist_q[1].q;
    assign dec_od_i = hist_q[0].i;
    assign dec_od_q = hist_q[0].q;

endmodule

// File: rtl/dfe_halfrate_cplx_chk.sv
// Property checker for dfe_halfrate_cplx, attached by bind below.
// Checks the reset state, the history shift and the candidate-to-decision path.
module dfe_halfrate_cplx_chk #(
    parameter int NTAP = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dec_ev_i,
    input logic              dec_ev_q,
    input logic              dec_od_i,
    input logic              dec_od_q,
    input logic [2*NTAP-1:0] hist_flat,
    input logic [15:0]       cand_flat
);

    logic in_rst_q;
    logic run_q;

    // Remember whether the previous edge was a reset or a normal update
    always_ff @(posedge clk) begin
        in_rst_q <= !rst_n;
        run_q    <= rst_n;
    end

    // R1
    always @(posedge clk) begin
        if (in_rst_q) begin
            reset_state_chk: assert ({dec_ev_i, dec_ev_q, dec_od_i, dec_od_q} == 4'hF
                                     && hist_flat == '1)
                else $error("reset did not fill the history with +1");
        end
    end

    for (genvar j = 2; j < NTAP; j++) begin : g_shift
        // R8
        hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
            run_q |-> hist_flat[2*j +: 2] == $past(hist_flat[2*(j-2) +: 2]));
    end

    // R4
    ev_i_unan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_flat[3:0] == 4'hF) |=> dec_ev_i);

    // R4
    ev_q_unan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_flat[7:4] == 4'h0) |=> !dec_ev_q);

    // R5
    od_i_unan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_flat[11:8] == 4'h0) |=> !dec_od_i);

    // R5
    od_q_unan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_flat[15:12] == 4'hF) |=> dec_od_q);

endmodule

bind dfe_halfrate_cplx dfe_halfrate_cplx_chk #(.NTAP(NTAP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_ev_i  (dec_ev_i),
    .dec_ev_q  (dec_ev_q),
    .dec_od_i  (dec_od_i),
    .dec_od_q  (dec_od_q),
    .hist_flat (hist_q),
    .cand_flat (cand_flat)
);

// File: tb/test_dfe_halfrate_cplx.sv
`timescale 1ns/1ps
// Self-checking bench: a table walk with zero feedback, then directed
// configurations compared against a full-rate reference equalizer.
module test_dfe_halfrate_cplx;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [7:0]   x_ev_i, x_ev_q, x_od_i, x_od_q;
    logic [127:0] comp_ofs;
    logic [95:0]  tap_coef;
    logic         dec_ev_i, dec_ev_q, dec_od_i, dec_od_q;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    int   cfg_ofs [2][2][4];
    int   cfg_dir [2][4];
    int   cfg_crs [2][4];
    bit   rh_i [5];
    bit   rh_q [5];
    logic [15:0] lfsr = 16'hACE1;

    // Rows: {ev_i, ev_q, od_i, od_q, expected {ev_i,ev_q,od_i,od_q}}
    localparam logic [35:0] TBL [12] = '{
        36'h0AF600FFA, 36'h7F800181A, 36'hFB05FB055, 36'h00000000F,
        36'hFFFFFFFF0, 36'h40C0C0409, 36'h01018080C, 36'h807F7F806,
        36'h2030F0E0C, 36'h9C6400FE6, 36'h7F7F7F7FF, 36'h800080005
    };

    always #2.5 clk = ~clk;

    dfe_halfrate_cplx i_dfe_halfrate_cplx (
        .clk (clk), .rst_n (rst_n),
        .x_ev_i (x_ev_i), .x_ev_q (x_ev_q), .x_od_i (x_od_i), .x_od_q (x_od_q),
        .comp_ofs (comp_ofs), .tap_coef (tap_coef),
        .dec_ev_i (dec_ev_i), .dec_ev_q (dec_ev_q),
        .dec_od_i (dec_od_i), .dec_od_q (dec_od_q)
    );

    task automatic clear_cfg();
        for (int l = 0; l < 2; l++)
            for (int c = 0; c < 2; c++)
                for (int h = 0; h < 4; h++) cfg_ofs[l][c][h] = 0;
        for (int c = 0; c < 2; c++)
            for (int k = 0; k < 4; k++) begin
                cfg_dir[c][k] = 0;
                cfg_crs[c][k] = 0;
            end
    endtask

    task automatic apply_cfg();
        for (int l = 0; l < 2; l++)
            for (int c = 0; c < 2; c++)
                for (int h = 0; h < 4; h++)
                    comp_ofs[((l*2+c)*4+h)*8 +: 8] = 8'(cfg_ofs[l][c][h]);
        for (int c = 0; c < 2; c++)
            for (int k = 0; k < 4; k++) begin
                tap_coef[(c*8+k)*6 +: 6]   = 6'(cfg_dir[c][k]);
                tap_coef[(c*8+4+k)*6 +: 6] = 6'(cfg_crs[c][k]);
            end
    endtask

    task automatic ref_reset();
        for (int j = 0; j < 5; j++) begin
            rh_i[j] = 1'b1;
            rh_q[j] = 1'b1;
        end
    endtask

    // Full-rate reference: one symbol, history entry j holds symbol n-1-j
    task automatic ref_step(input int xi, input int xq, input int lane,
                            output bit bi, output bit bq);
        int hyp, acc_i, acc_q, vi, vq;
        hyp   = rh_i[0] * 2 + rh_q[0];
        acc_i = xi + cfg_ofs[lane][0][hyp];
        acc_q = xq + cfg_ofs[lane][1][hyp];
        for (int t = 2; t <= 5; t++) begin
            vi = rh_i[t-1] ? 1 : -1;
            vq = rh_q[t-1] ? 1 : -1;
            acc_i = acc_i - vi * cfg_dir[0][t-2] - vq * cfg_crs[0][t-2];
            acc_q = acc_q - vq * cfg_dir[1][t-2] - vi * cfg_crs[1][t-2];
        end
        bi = (acc_i >= 0);
        bq = (acc_q >= 0);
        for (int j = 4; j > 0; j--) begin
            rh_i[j] = rh_i[j-1];
            rh_q[j] = rh_q[j-1];
        end
        rh_i[0] = bi;
        rh_q[0] = bq;
    endtask

    function automatic int sx(logic [7:0] v);
        return int'(signed'(v));
    endfunction

    task automatic check2(input string tag, input string what,
                          input logic [1:0] got, input logic [1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, got, exp);
        end
    endtask

    // Drive one pair at a falling edge, check after the next rising edge
    task automatic run_pair(input logic [7:0] ei, input logic [7:0] eq,
                            input logic [7:0] oi, input logic [7:0] oq,
                            input string te, input string to);
        bit e_i, e_q, o_i, o_q;
        x_ev_i = ei; x_ev_q = eq; x_od_i = oi; x_od_q = oq;
        ref_step(sx(ei), sx(eq), 0, e_i, e_q);
        ref_step(sx(oi), sx(oq), 1, o_i, o_q);
        @(posedge clk);
        @(negedge clk);
        check2(te, "even lane", {dec_ev_i, dec_ev_q}, {e_i, e_q});
        check2(to, "odd lane",  {dec_od_i, dec_od_q}, {o_i, o_q});
    endtask

    function automatic logic [7:0] next_sample(int shift);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return 8'(signed'(lfsr[7:0]) >>> shift);
    endfunction

    task automatic run_random(input int npairs, input int shift,
                              input string te, input string to);
        logic [7:0] a, b, c, d;
        for (int p = 0; p < npairs; p++) begin
            a = next_sample(shift);
            b = next_sample(shift);
            c = next_sample(shift);
            d = next_sample(shift);
            run_pair(a, b, c, d, te, to);
        end
    endtask

    task automatic do_reset(input string tag);
        rst_n = 1'b0;
        apply_cfg();
        repeat (4) @(negedge clk);
        check2(tag, "reset state", {dec_ev_i, dec_ev_q}, 2'b11);
        check2(tag, "reset state", {dec_od_i, dec_od_q}, 2'b11);
        rst_n = 1'b1;
        ref_reset();
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        x_ev_i = '0; x_ev_q = '0; x_od_i = '0; x_od_q = '0;
        comp_ofs = '0; tap_coef = '0;
        clear_cfg();
        // R1: reset state with zero configuration
        do_reset("R1");

        // R2: negative samples show up after exactly one rising edge
        run_pair(8'hFF, 8'hFF, 8'hFF, 8'hFF, "R2", "R2");

        // R3: table walk with no feedback and no offsets, sign slicing
        for (int r = 0; r < 12; r++) begin
            x_ev_i = TBL[r][35:28]; x_ev_q = TBL[r][27:20];
            x_od_i = TBL[r][19:12]; x_od_q = TBL[r][11:4];
            @(posedge clk);
            @(negedge clk);
            check2("R3", "table even", {dec_ev_i, dec_ev_q}, TBL[r][3:2]);
            check2("R3", "table odd",  {dec_od_i, dec_od_q}, TBL[r][1:0]);
        end

        // R4 and R5: offsets only, spread so that hypotheses disagree
        clear_cfg();
        cfg_ofs[0][0] = '{-75, -25, 25, 75};
        cfg_ofs[0][1] = '{75, 25, -25, -75};
        cfg_ofs[1][0] = '{60, -60, 20, -20};
        cfg_ofs[1][1] = '{-20, 20, -60, 60};
        do_reset("R1");
        run_random(64, 1, "R4", "R5");

        // R6: direct taps only, then a mid-stream reset (R1)
        clear_cfg();
        cfg_dir[0] = '{20, -15, 10, -7};
        cfg_dir[1] = '{-18, 12, -9, 5};
        do_reset("R1");
        run_random(64, 1, "R6", "R6");
        do_reset("R1");
        run_random(8, 1, "R1", "R1");

        // R7: cross taps only
        clear_cfg();
        cfg_crs[0] = '{17, -11, 8, -4};
        cfg_crs[1] = '{-16, 13, -6, 3};
        do_reset("R1");
        run_random(64, 1, "R7", "R7");

        // R8: only tap 5 is large, small samples
        clear_cfg();
        cfg_dir[0][3] = 31;
        cfg_crs[1][3] = -32;
        do_reset("R1");
        run_random(64, 3, "R8", "R8");

        // R9: extreme weights, offsets and samples
        clear_cfg();
        cfg_dir[0] = '{-32, 31, -32, 31};
        cfg_dir[1] = '{31, -32, 31, -32};
        cfg_crs[0] = '{31, 31, -32, -32};
        cfg_crs[1] = '{-32, -32, 31, 31};
        cfg_ofs[0][0] = '{127, -128, 127, -128};
        cfg_ofs[0][1] = '{-128, 127, -128, 127};
        cfg_ofs[1][0] = '{-128, -128, 127, 127};
        cfg_ofs[1][1] = '{127, 127, -128, -128};
        do_reset("R1");
        run_random(64, 0, "R9", "R9");
        run_pair(8'h80, 8'h7F, 8'h80, 8'h7F, "R9", "R9");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule